// File: doc/BRIEF.md
# Chroma-Key Pixel Merger

A streaming merge unit that lays a foreground picture over a background picture wherever the foreground shows a chosen key colour. Each accepted beat carries eight 8-bit foreground pixels and the eight background pixels at the same positions. Every foreground byte is compared with the key. The result is a per-byte mask whose bytes are all ones or all zeros. The output word is then built from bitwise operations only: the foreground with the mask cleared, ORed with the background with the mask kept. No pixel goes through a per-pixel conditional select.

The key colour is an 8-bit register written through its own strobe. It is copied into every byte lane for the compare. The datapath is a two-stage pipeline. Stage one forms the match mask and registers it with both pixel words. Stage two widens the mask to bytes, merges, and registers the result. Ready propagates back through both stages, so a stalled consumer holds the pipeline without losing beats. An 8-bit match vector leaves the block alongside each merged word for debug.

Top module: `chroma_key_merger`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and the key register holds 0x00.
- R2: Bit i of match_o is 1 exactly when foreground byte i (bits 8i+7..8i) of the beat equals the key that applied to that beat.
- R3: Byte i of merged_o equals background byte i when that lane matched the key, and foreground byte i otherwise.
- R4: A cycle with key_we_i high loads key_data_i into the key at that clock edge. A beat accepted in the same cycle still uses the old key, and beats accepted in later cycles use the new one.
- R5: With the pipeline empty and out_ready_i high, a beat accepted at a clock edge appears on the output two clock edges later.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, merged_o and match_o hold their values.
- R7: Every accepted beat leaves the block exactly once, in acceptance order, under any pattern of in_valid_i and out_ready_i.
- R8: Whenever out_ready_i is 1, in_ready_o is 1, so a continuous stream passes at one beat per cycle.
- R9: While key_we_i is 0, changes on key_data_i have no effect on the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_we_i | input | 1 | Key register write strobe |
| key_data_i | input | 8 | New key colour |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat can be accepted |
| fg_i | input | 64 | Eight foreground pixels, byte i is pixel i |
| bg_i | input | 64 | Eight background pixels, byte i is pixel i |
| out_valid_o | output | 1 | Merged beat valid |
| out_ready_i | input | 1 | Consumer accepts the merged beat |
| merged_o | output | 64 | Merged pixels |
| match_o | output | 8 | Per-pixel key match vector for the beat on merged_o |

## Verification
A mask bit stored in the wrong lane, or kept from an earlier beat, shows up two edges after acceptance: match_o disagrees with the lanes of that beat, and merged_o carries a wrong byte. A broken valid or ready flop loses a beat or repeats one. The in-order scoreboard catches this at the next output handshake. It also catches a key update taking effect one cycle early or late, because the beats that straddle a key write are then merged against the wrong colour. Stage holding under backpressure is compared on every stalled cycle. A stall that lets data slip shows up within one cycle.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  parameter int unsigned LANES = 8;
  parameter int unsigned PIX_W = 8;
  localparam int unsigned WORD_W = LANES * PIX_W;
endpackage

// File: rtl/ckm_mask_stage.sv
module ckm_mask_stage #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned W = LANES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [W-1:0]     fg_i,
  input  logic [W-1:0]     bg_i,
  input  logic [PIX_W-1:0] key_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [W-1:0]     fg_o,
  output logic [W-1:0]     bg_o,
  output logic [LANES-1:0] hit_o
);
  logic [LANES-1:0] hit_d;
  logic             valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit_d[g] = (fg_i[g*PIX_W +: PIX_W] == key_i);
  end

  assign ready_o = !valid_q || ready_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fg_o    <= '0;
      bg_o    <= '0;
      hit_o   <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) begin
        fg_o  <= fg_i;
        bg_o  <= bg_i;
        hit_o <= hit_d;
      end
    end
  end
endmodule

// File: rtl/ckm_merge_stage.sv
module ckm_merge_stage #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned W = LANES * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [W-1:0]     fg_i,
  input  logic [W-1:0]     bg_i,
  input  logic [LANES-1:0] hit_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [W-1:0]     merged_o,
  output logic [LANES-1:0] hit_o
);
  logic [W-1:0] byte_mask;
  logic [W-1:0] merged_d;
  logic         valid_q;

  // each lane bit widens to a full byte of ones or zeros
  for (genvar g = 0; g < LANES; g++) begin : g_widen
    assign byte_mask[g*PIX_W +: PIX_W] = {PIX_W{hit_i[g]}};
  end

  assign merged_d = (fg_i & ~byte_mask) | (bg_i & byte_mask);
  assign ready_o  = !valid_q || ready_i;
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      merged_o <= '0;
      hit_o    <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) begin
        merged_o <= merged_d;
        hit_o    <= hit_i;
      end
    end
  end
endmodule

// File: rtl/chroma_key_merger.sv
module chroma_key_merger #(
  parameter int unsigned LANES = ckm_pkg::LANES,
  parameter int unsigned PIX_W = ckm_pkg::PIX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   key_we_i,
  input  logic [PIX_W-1:0]       key_data_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [LANES*PIX_W-1:0] fg_i,
  input  logic [LANES*PIX_W-1:0] bg_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [LANES*PIX_W-1:0] merged_o,
  output logic [LANES-1:0]       match_o
);
  localparam int unsigned W = LANES * PIX_W;

  logic [PIX_W-1:0] key_q;
  logic             s1_valid, s2_ready;
  logic [W-1:0]     s1_fg, s1_bg;
  logic [LANES-1:0] s1_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       key_q <= '0;
    else if (key_we_i) key_q <= key_data_i;
  end

  ckm_mask_stage #(.LANES(LANES), .PIX_W(PIX_W)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .fg_i    (fg_i),
    .bg_i    (bg_i),
    .key_i   (key_q),
    .valid_o (s1_valid),
    .ready_i (s2_ready),
    .fg_o    (s1_fg),
    .bg_o    (s1_bg),
    .hit_o   (s1_hit)
  );

  ckm_merge_stage #(.LANES(LANES), .PIX_W(PIX_W)) i_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .ready_o  (s2_ready),
    .fg_i     (s1_fg),
    .bg_i     (s1_bg),
    .hit_i    (s1_hit),
    .valid_o  (out_valid_o),
    .ready_i  (out_ready_i),
    .merged_o (merged_o),
    .hit_o    (match_o)
  );
endmodule

// File: rtl/ckm_checker.sv
module ckm_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PIX_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   key_we_i,
  input logic [PIX_W-1:0]       key_q,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic [LANES*PIX_W-1:0] merged_o,
  input logic [LANES-1:0]       match_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!out_valid_o && in_ready_o && key_q == '0); // R1
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(merged_o) && $stable(match_o))); // R6

  AST_READY_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o); // R8

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o, 2)); // R5

  AST_KEY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_we_i |=> $stable(key_q)); // R9
endmodule

bind chroma_key_merger ckm_checker #(.LANES(LANES), .PIX_W(PIX_W)) i_ckm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_we_i    (key_we_i),
  .key_q       (key_q),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .merged_o    (merged_o),
  .match_o     (match_o)
);

// File: tb/test_chroma_key_merger.sv
module test_chroma_key_merger;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_we_i = 1'b0;
  logic [7:0]  key_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] fg_i = '0;
  logic [63:0] bg_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [63:0] merged_o;
  logic [7:0]  match_o;

  chroma_key_merger i_chroma_key_merger (.*);

  always #5 clk_i = ~clk_i;

  int unsigned errors = 0, checks = 0, cycles = 0;
  logic [71:0] exp_q[$];
  logic [7:0]  key_m = 8'h00;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_merged;
  logic [7:0]  prev_match;
  string       tag = "R7";

  function automatic logic [7:0] f_match(input logic [63:0] fg, input logic [7:0] k);
    for (int i = 0; i < 8; i++) f_match[i] = (fg[i*8 +: 8] == k);
  endfunction

  function automatic logic [63:0] f_merge(input logic [63:0] fg, input logic [63:0] bg, input logic [7:0] k);
    for (int i = 0; i < 8; i++) f_merge[i*8 +: 8] = (fg[i*8 +: 8] == k) ? bg[i*8 +: 8] : fg[i*8 +: 8];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 72'(cycles), 72'd100000);
      finish_run();
    end
  end

  task automatic step(input logic v, input logic [63:0] f, input logic [63:0] b,
                      input logic rdy, input logic kwe, input logic [7:0] kd);
    logic [71:0] e;
    @(negedge clk_i);
    in_valid_i = v; fg_i = f; bg_i = b; out_ready_i = rdy; key_we_i = kwe; key_data_i = kd;
    #1;
    if (prev_stall)
      chk(out_valid_o && merged_o == prev_merged && match_o == prev_match, "R6",
          {match_o, merged_o}, {prev_match, prev_merged});
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 extra beat", {match_o, merged_o}, 72'd0);
      else begin
        e = exp_q.pop_front();
        chk(match_o == e[71:64], {"R2 ", tag}, 72'(match_o), 72'(e[71:64]));
        chk(merged_o == e[63:0], {"R3 ", tag}, 72'(merged_o), 72'(e[63:0]));
      end
    end
    if (in_valid_i && in_ready_o) exp_q.push_back({f_match(f, key_m), f_merge(f, b, key_m)});
    if (key_we_i) key_m = kd;
    prev_stall = out_valid_o && !out_ready_i;
    prev_merged = merged_o; prev_match = match_o;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b1, 1'b0, 8'h00);
    chk(exp_q.size() == 0 && !out_valid_o, "R7 drained", 72'(exp_q.size()), 72'd0);
  endtask

  function automatic logic [63:0] keyed_word(input logic [7:0] k, input int pct);
    for (int i = 0; i < 8; i++)
      keyed_word[i*8 +: 8] = (($urandom % 100) < pct) ? k : 8'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(!out_valid_o && in_ready_o, "R1 reset", {70'd0, out_valid_o, in_ready_o}, 72'd1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset key is 0x00
    tag = "R1 key";
    step(1'b1, 64'h00_11_00_22_00_33_00_44, 64'hA1A2A3A4A5A6A7A8, 1'b1, 1'b0, 8'h00);
    drain();

    // R5: two-edge latency
    tag = "R5";
    step(1'b1, 64'h0102030405060708, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'h00);
    step(1'b0, '0, '0, 1'b1, 1'b0, 8'h00);
    chk(!out_valid_o, "R5 early", 72'(out_valid_o), 72'd0);
    step(1'b0, '0, '0, 1'b1, 1'b0, 8'h00);
    chk(out_valid_o, "R5 due", 72'(out_valid_o), 72'd1);
    drain();

    // R4: write key, same-cycle beat uses old key, next uses new
    tag = "R4";
    step(1'b1, {8{8'h3C}}, {8{8'h99}}, 1'b1, 1'b1, 8'h3C);
    step(1'b1, {8{8'h3C}}, {8{8'h99}}, 1'b1, 1'b0, 8'h00);
    step(1'b1, 64'h3C00_3C00_3C00_3C00, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 8'h00);
    drain();

    // R9: key_data toggles with strobe low
    tag = "R9";
    for (int i = 0; i < 6; i++)
      step(1'b1, {8{8'h3C}} ^ (64'hFF << (i*8)), {8{8'h5A}}, 1'b1, 1'b0, 8'(i*37 + 1));
    drain();

    // R8: continuous stream keeps in_ready high
    tag = "R8";
    for (int i = 0; i < 20; i++) begin
      step(1'b1, keyed_word(key_m, 50), {$urandom, $urandom}, 1'b1, 1'b0, 8'h00);
      chk(in_ready_o, "R8 ready", 72'(in_ready_o), 72'd1);
    end
    drain();

    // R6: full stall then release
    tag = "R6";
    for (int i = 0; i < 6; i++)
      step(1'b1, keyed_word(key_m, 50), {$urandom, $urandom}, 1'b0, 1'b0, 8'h00);
    chk(!in_ready_o, "R6 backpressure", 72'(in_ready_o), 72'd0);
    drain();

    // R7: random traffic, random backpressure, random key writes
    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic kw;
      kw = ($urandom % 16) == 0;
      step(($urandom % 4) != 0, keyed_word(key_m, 40), {$urandom, $urandom},
           ($urandom % 3) != 0, kw, 8'($urandom % 4));
    end
    drain();

    finish_run();
  end
endmodule